// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is an on-chip scratchpad split into interleaved banks that serves a group of lanes in one request. Each lane brings an active flag, a word address, a write select and write data. Each bank can deliver one distinct storage word per cycle. When lanes collide in a bank, the block works through them over extra cycles. All lanes that ask for the word a bank is serving in a cycle get that word together, so identical addresses cost nothing extra.

A request is taken on a clock edge where `req_valid` is high and `busy` is low. The mapping mode is sampled with the request. In narrow mode a word is 32 bits. In wide mode the banks interleave on 64-bit words, so the two 32-bit halves of one wide word fall in the same bank and count as one access. `busy` stays high for as many cycles as the worst bank needs. Then a single `done` pulse presents the read results of every lane at once.

Top module: `scratch_serializer`

## Requirements
- R1: After reset `busy` and `done` are 0, every `lane_rdata` lane is 0 and every storage word reads as 0.
- R2: The storage is a flat array of `BANKS*ROWS` 32-bit words indexed by the lane address. The access key is the address in narrow mode (`wide_mode`=0) and the address shifted right by one in wide mode. The bank is the key modulo `BANKS`.
- R3: Active lanes that give the same address in one request are served together. A request where all lanes hit one word keeps `busy` high for exactly one cycle.
- R4: In wide mode, lanes addressing the two 32-bit halves of one 64-bit word share a key and are served in the same cycle without conflict.
- R5: After a request is accepted, `busy` is high for exactly N cycles, where N is the largest number of distinct keys among the active lanes of any one bank. A request with no active lane gives no `busy` and a `done` pulse in the following cycle.
- R6: In every busy cycle each bank serves the key of its lowest-numbered pending lane, together with every other pending lane in that bank that carries the same key.
- R7: When several lanes served in one cycle write the same address, the highest-numbered of them sets the stored value.
- R8: A request raised while `busy` is high is ignored and does not change any stored word or returned data.
- R9: `done` is a one-cycle pulse in the cycle after `busy` falls. At that point `lane_rdata` holds, for every reading lane, its read value, and 0 for idle or writing lanes. These values stay unchanged until the next request is accepted.
- R10: A read returns the word as it stood at the start of its service cycle. It sees writes from earlier service cycles of the same request but not writes made in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| wide_mode | input | 1 | 1 selects 64-bit interleave |
| lane_active | input | LANES | Per-lane participation flag |
| lane_we | input | LANES | Per-lane write select (1 = write) |
| lane_addr | input | LANES*AW | Packed word addresses, lane 0 in the low bits |
| lane_wdata | input | LANES*32 | Packed write data, lane 0 in the low bits |
| busy | output | 1 | High while conflicting accesses are being served |
| done | output | 1 | One-cycle completion pulse |
| lane_rdata | output | LANES*32 | Packed read results, lane 0 in the low bits |

## Verification
The assertions rely on the request being stable only on its acceptance edge. They do not assume that `req_valid` stays low while `busy` is high. The stimulus therefore drives random addresses, modes and strobes during busy cycles to exercise the ignore rule. Addresses always stay inside the `BANKS*ROWS` word range, so no lane can index past the storage. Requests are mixed so that some pile into one bank and others spread across banks, and wide-mode halves are paired. This covers the per-bank serialization count, the broadcast case and the same-cycle write resolution.

// File: rtl/scratch_serializer.sv
module scratch_serializer #(
  parameter int BANKS = 16,
  parameter int ROWS  = 16,
  parameter int LANES = 8,
  parameter int DW    = 32,
  localparam int WORDS = BANKS * ROWS,
  localparam int AW    = $clog2(WORDS),
  localparam int BW    = $clog2(BANKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                wide_mode,
  input  logic [LANES-1:0]    lane_active,
  input  logic [LANES-1:0]    lane_we,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES*DW-1:0] lane_wdata,
  output logic                busy,
  output logic                done,
  output logic [LANES*DW-1:0] lane_rdata
);

  logic [DW-1:0] mem [WORDS];
  logic [LANES-1:0]         pend, we_q, sel;
  logic [LANES-1:0][AW-1:0] addr_q, key;
  logic [LANES-1:0][DW-1:0] wd_q, rd_q;
  logic [LANES-1:0][BW-1:0] bank;
  logic                     wide_q;

  assign lane_rdata = rd_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      key[l]  = wide_q ? (addr_q[l] >> 1) : addr_q[l];
      bank[l] = key[l][BW-1:0];
    end
    for (int l = 0; l < LANES; l++) begin : pick
      logic          found;
      logic [AW-1:0] lead;
      found = 1'b0;
      lead  = key[l];
      for (int j = 0; j < LANES; j++)
        if (!found && pend[j] && bank[j] == bank[l]) begin
          found = 1'b1;
          lead  = key[j];
        end
      sel[l] = pend[l] && key[l] == lead;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      pend   <= '0;
      we_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      wide_q <= 1'b0;
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          pend   <= lane_active;
          we_q   <= lane_we;
          addr_q <= lane_addr;
          wd_q   <= lane_wdata;
          wide_q <= wide_mode;
          rd_q   <= '0;
          if (|lane_active) busy <= 1'b1;
          else              done <= 1'b1;
        end
      end else begin
        pend <= pend & ~sel;
        for (int l = 0; l < LANES; l++)
          if (sel[l]) begin
            if (we_q[l]) mem[addr_q[l]] <= wd_q[l];
            else         rd_q[l]        <= mem[addr_q[l]];
          end
        if ((pend & ~sel) == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5
  progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $countones(pend) < $past($countones(pend)));

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(we_q) && $stable(wd_q) && $stable(wide_q)));

  // R6
  one_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> sel != '0);

  for (genvar i = 0; i < LANES; i++) begin : g_pi
    for (genvar j = i + 1; j < LANES; j++) begin : g_pj
      // R6
      bank_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel[i] && sel[j] && bank[i] == bank[j]) |-> key[i] == key[j]);
    end
  end

endmodule

// File: tb/scratch_serializer_test.sv
module scratch_serializer_test;
  localparam int PERIOD = 10;
  localparam int BANKS = 16, ROWS = 16, LANES = 8, DW = 32;
  localparam int WORDS = BANKS * ROWS;
  localparam int AW = $clog2(WORDS);

  logic clk = 0, rst_n = 0, req_valid = 0, wide_mode = 0;
  logic [LANES-1:0] lane_active = '0, lane_we = '0;
  logic [LANES*AW-1:0] lane_addr = '0;
  logic [LANES*DW-1:0] lane_wdata = '0;
  logic busy, done;
  logic [LANES*DW-1:0] lane_rdata;

  scratch_serializer #(.BANKS(BANKS), .ROWS(ROWS), .LANES(LANES), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wide_mode(wide_mode),
    .lane_active(lane_active), .lane_we(lane_we), .lane_addr(lane_addr),
    .lane_wdata(lane_wdata), .busy(busy), .done(done), .lane_rdata(lane_rdata));

  always #(PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  int unsigned mm [WORDS];
  bit ta [LANES];
  bit tw [LANES];
  int ad [LANES];
  int unsigned wv [LANES];

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int keyof(bit wide, int a);
    return wide ? (a >> 1) : a;
  endfunction

  task automatic run(input bit wide, input string tag, input bit noise);
    bit pend [LANES];
    int unsigned erd [LANES];
    int rounds = 0;
    bit any;
    for (int l = 0; l < LANES; l++) begin pend[l] = ta[l]; erd[l] = 0; end
    any = 1;
    while (any) begin
      bit srv [LANES];
      any = 0;
      for (int l = 0; l < LANES; l++) begin srv[l] = 0; any |= pend[l]; end
      if (!any) break;
      for (int b = 0; b < BANKS; b++) begin
        int lead = -1;
        for (int l = 0; l < LANES; l++)
          if (lead < 0 && pend[l] && keyof(wide, ad[l]) % BANKS == b) lead = l;
        if (lead >= 0)
          for (int l = 0; l < LANES; l++)
            if (pend[l] && keyof(wide, ad[l]) == keyof(wide, ad[lead])) srv[l] = 1;
      end
      for (int l = 0; l < LANES; l++) if (srv[l] && !tw[l]) erd[l] = mm[ad[l]];
      for (int l = 0; l < LANES; l++) if (srv[l] && tw[l]) mm[ad[l]] = wv[l];
      for (int l = 0; l < LANES; l++) if (srv[l]) pend[l] = 0;
      rounds++;
    end
    wide_mode = wide;
    for (int l = 0; l < LANES; l++) begin
      lane_active[l] = ta[l];
      lane_we[l] = tw[l];
      lane_addr[l*AW +: AW] = AW'(ad[l]);
      lane_wdata[l*DW +: DW] = wv[l];
    end
    req_valid = 1;
    @(negedge clk);
    req_valid = noise;
    for (int i = 1; i <= rounds; i++) begin
      if (noise) begin
        wide_mode = 1'($urandom);
        lane_active = LANES'($urandom);
        lane_we = LANES'($urandom);
        lane_addr = {($urandom), ($urandom)};
        lane_wdata = {($urandom), ($urandom), ($urandom), ($urandom), ($urandom), ($urandom), ($urandom), ($urandom)};
      end
      cmp({tag, " R5 busy"}, {busy, done}, 2'b10);
      @(negedge clk);
    end
    req_valid = 0;
    cmp({tag, " R9 done"}, {busy, done}, 2'b01);
    for (int l = 0; l < LANES; l++) cmp({tag, " R9 rdata"}, lane_rdata[l*DW +: DW], erd[l]);
    @(negedge clk);
    cmp({tag, " R9 pulse"}, {busy, done}, 2'b00);
    for (int l = 0; l < LANES; l++) cmp({tag, " R9 hold"}, lane_rdata[l*DW +: DW], erd[l]);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < WORDS; w++) mm[w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cmp("R1 busy/done", {busy, done}, 2'b00);
    cmp("R1 rdata", lane_rdata, '0);
    // R5 R6: eight writes to distinct words of bank 0
    for (int l = 0; l < LANES; l++) begin ta[l] = 1; tw[l] = 1; ad[l] = l * BANKS; wv[l] = 32'hA000 + l; end
    run(0, "R5 bank0 writes", 0);
    // R3 broadcast read
    for (int l = 0; l < LANES; l++) begin tw[l] = 0; ad[l] = 2 * BANKS; end
    run(0, "R3 broadcast", 0);
    // R4 wide halves, two wide words in bank 0
    for (int l = 0; l < LANES; l++) begin tw[l] = 0; ad[l] = (l < 4) ? (l % 2) : (2 * BANKS + l % 2); end
    run(1, "R4 wide halves", 0);
    // R7 same-word writes
    for (int l = 0; l < LANES; l++) begin tw[l] = 1; ad[l] = 5; wv[l] = 32'hB000 + l; end
    run(0, "R7 write winner", 0);
    for (int l = 0; l < LANES; l++) begin tw[l] = 0; ad[l] = 5; end
    run(0, "R7 readback", 0);
    // R10 ordering: write and same-word read in round 1, other key later
    for (int l = 0; l < LANES; l++) begin ta[l] = 0; tw[l] = 0; end
    ta[0] = 1; tw[0] = 1; ad[0] = 3; wv[0] = 32'hC3C3;
    ta[1] = 1; ad[1] = 3 + BANKS;
    ta[2] = 1; ad[2] = 3;
    ta[3] = 1; tw[3] = 1; ad[3] = 3 + BANKS; wv[3] = 32'hD4;
    ta[4] = 1; ad[4] = 3 + 2 * BANKS;
    run(0, "R10 ordering", 0);
    for (int l = 0; l < LANES; l++) begin ta[l] = 1; tw[l] = 0; ad[l] = 3 + (l % 3) * BANKS; end
    run(0, "R10 readback", 0);
    // R5 empty request
    for (int l = 0; l < LANES; l++) ta[l] = 0;
    run(0, "R5 empty", 0);
    // R8 random traffic with noise while busy, R2 R6 mixing
    for (int n = 0; n < 80; n++) begin
      for (int l = 0; l < LANES; l++) begin
        ta[l] = ($urandom % 5) != 0;
        tw[l] = $urandom % 2;
        ad[l] = ($urandom % 2) ? int'(($urandom % 6) * BANKS + ($urandom % 3)) : int'($urandom % WORDS);
        wv[l] = $urandom;
      end
      run(n % 3 == 0, "R8 R2 random", 1);
    end
    // R2 full readback in narrow mode
    for (int k = 0; k < WORDS / LANES; k++) begin
      for (int l = 0; l < LANES; l++) begin ta[l] = 1; tw[l] = 0; ad[l] = k * LANES + l; end
      run(0, "R2 readback", 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule